// File: doc/BRIEF.md
# Endpoint handshake and toggle controller

This block holds the per-endpoint control state of a full-speed USB device function with four endpoints. Endpoint 0 carries control transfers. Endpoints 1 and 2 are bulk endpoints, and each one's direction is chosen at run time. Endpoint 3 is an interrupt IN endpoint. For each endpoint the block keeps a configured bit, a stall bit, a receive-ready flag, a transmit-ready flag and a DATA0/DATA1 sequence bit. For endpoint 0 it also keeps a setup-ready flag and the control-transfer stage.

A protocol engine feeds the block with token arrivals, the outcome of each received data packet, ACKs from the host and a bus-reset detection. One cycle after each token, the block answers with a handshake decision and the data PID parity that goes with it. A local processor changes the state through a small write port. Some writes set a bit when a 1 is written, some clear a bit when a 1 is written, and some load a field. A 0 bit in any of these writes leaves the matching state alone. The FIFO arrays sit outside the block. The block sends them one flush pulse per endpoint.

Top module: `ep_hs_ctrl`

## Requirements
- R1: After synchronous reset (rst_n low at a clock edge), every flag, configured bit, stall bit and sequence bit reads 0, flush_o is 0, and ep0_stage_o is 00.
- R2: A good data packet (rx_done_i with rx_err_i=0, rx_setup_i=0) on a configured OUT-capable endpoint sets that endpoint's rx_ready_o bit and flips its seq_o bit. While rx_ready_o is set, an OUT token (kind 0) to that endpoint answers NAK (code 2). An OUT token to an endpoint that is not OUT-capable (endpoint 3, or endpoint 1/2 in IN mode) answers code 0.
- R3: A write to address 1 clears rx_ready_o[k] for each bit k (0..2) of wr_data_i that is 1. Bits that are 0 leave their flag unchanged.
- R4: A write to address 0 sets tx_ready_o[k] for each bit k (0..3) of wr_data_i that is 1, provided endpoint k can transmit. An IN token (kind 1) then answers accept (code 1), with hs_pid_odd_o equal to the endpoint's sequence bit. With tx_ready_o clear, an IN token answers NAK. An ACK for the endpoint clears tx_ready_o and flips the sequence bit.
- R5: A token to an unconfigured endpoint answers code 0. A bus_reset_i pulse sets the endpoint 0 configured bit and clears all other configured bits, stalls, ready flags and sequence bits. Configured bits for endpoints 1..3 are loaded from wr_data_i[3:1] by a write to address 2.
- R6: Stall bits are loaded from wr_data_i[7:4] (endpoint 0..3) by a write to address 2. A configured, direction-valid IN or OUT token to a stalled endpoint answers STALL (code 3).
- R7: A write to address 4 forces seq_o[k] to 0 for each bit k of wr_data_i[3:0] that is 1.
- R8: A write to address 3 loads the mode: bit 0 selects IN for endpoint 1, bit 1 selects IN for endpoint 2, and bit 2 selects rate-feedback for endpoint 3. In rate-feedback mode, endpoint 3's sequence bit flips when transmit-ready is set and stays put on ACK. Otherwise it flips on ACK only.
- R9: A good setup packet (rx_setup_i=1) on endpoint 0 sets setup_ready_o and rx_ready_o[0], and sets seq_o[0] to 1. A SETUP token (kind 2) to configured endpoint 0 answers accept. Writing 1 to bit 0 at address 6 clears setup_ready_o. It also clears rx_ready_o[0] only if the setup announced a host-to-device data stage (setup_in_dir_i=0 and setup_len_nz_i=1).
- R10: A write to address 5 with bit k (1..3) set clears tx_ready_o[k] and pulses flush_o[k] high for one cycle, but only for endpoints that currently transmit.
- R11: ep0_stage_o reads 00 for setup, 01 for data and 10 for status. A setup packet moves the stage to 01 if it has data, and to 10 if it has none. An accepted endpoint 0 token in the direction opposite to the data stage moves the stage to 10. The status stage's closing event moves the stage back to 00: an ACK for an OUT-type control transfer, or a good OUT packet for an IN-type one.
- R12: A received packet reported with rx_err_i=1 changes no ready flag and no sequence bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_reset_i | input | 1 | One-cycle pulse: USB bus reset detected |
| tok_valid_i | input | 1 | Token arrived this cycle |
| tok_ep_i | input | 2 | Token endpoint number |
| tok_kind_i | input | 2 | Token kind: 0 OUT, 1 IN, 2 SETUP |
| rx_done_i | input | 1 | Data packet reception finished |
| rx_err_i | input | 1 | Finished packet had an error |
| rx_ep_i | input | 2 | Endpoint of the finished packet |
| rx_setup_i | input | 1 | Finished packet is an 8-byte setup packet |
| setup_in_dir_i | input | 1 | Setup announces a device-to-host transfer |
| setup_len_nz_i | input | 1 | Setup announces a non-empty data stage |
| ack_i | input | 1 | Host returned ACK |
| ack_ep_i | input | 2 | Endpoint the ACK belongs to |
| wr_en_i | input | 1 | Processor write strobe |
| wr_addr_i | input | 3 | Processor write address |
| wr_data_i | input | 8 | Processor write data |
| hs_valid_o | output | 1 | Handshake decision valid (one cycle after a token) |
| hs_code_o | output | 2 | 0 none, 1 accept, 2 NAK, 3 STALL |
| hs_pid_odd_o | output | 1 | Data PID parity: 1 means DATA1 |
| cfg_o | output | 4 | Configured bit per endpoint |
| stall_o | output | 4 | Stall bit per endpoint |
| rx_ready_o | output | 4 | Receive-ready per endpoint (bit 3 always 0) |
| tx_ready_o | output | 4 | Transmit-ready per endpoint |
| seq_o | output | 4 | Sequence bit per endpoint |
| setup_ready_o | output | 1 | Setup packet waiting on endpoint 0 |
| ep0_stage_o | output | 2 | Endpoint 0 control stage |
| flush_o | output | 4 | One-cycle FIFO flush pulse per endpoint (bit 0 always 0) |

## Verification
A flag stuck or cleared at the wrong time shows up in the very next token's answer. A locked endpoint that answers accept, or an armed endpoint that answers NAK, is visible on hs_code_o one cycle after the token. A wrong sequence bit appears on hs_pid_odd_o at the next accepted token, and on seq_o one cycle after the event that should have flipped it. Stage tracking errors surface on ep0_stage_o two cycles after the accepted token. Missed flushes appear on flush_o and tx_ready_o one cycle after the write.

// File: rtl/ep_hs_pkg.sv
// Shared encodings for the endpoint handshake and toggle controller.
// Assumes a fixed four-endpoint layout: control, two bulk, one interrupt.
package ep_hs_pkg;
    localparam int NUM_EP = 4;
    localparam int EP_W   = $clog2(NUM_EP);
    localparam int RA_W   = 3;
    localparam int WD_W   = 8;

    localparam int EK_CTRL = 0;
    localparam int EK_BULK = 1;
    localparam int EK_INTR = 2;

    typedef enum logic [1:0] {
        TK_OUT = 2'd0, TK_IN = 2'd1, TK_SETUP = 2'd2, TK_RSVD = 2'd3
    } tok_kind_e;

    typedef enum logic [1:0] {
        HS_NONE = 2'd0, HS_GO = 2'd1, HS_NAK = 2'd2, HS_STALL = 2'd3
    } hs_code_e;

    typedef enum logic [1:0] {
        ST_SETUP = 2'd0, ST_DATA = 2'd1, ST_STATUS = 2'd2, ST_RSVD = 2'd3
    } ep0_stage_e;

    localparam logic [RA_W-1:0] RA_ARM      = 3'd0;
    localparam logic [RA_W-1:0] RA_RELEASE  = 3'd1;
    localparam logic [RA_W-1:0] RA_ATTR     = 3'd2;
    localparam logic [RA_W-1:0] RA_MODE     = 3'd3;
    localparam logic [RA_W-1:0] RA_SEQCLR   = 3'd4;
    localparam logic [RA_W-1:0] RA_FLUSH    = 3'd5;
    localparam logic [RA_W-1:0] RA_SETUPACK = 3'd6;
endpackage

// File: rtl/ep_hs_slot.sv
// One endpoint's state: configured, stall, direction/rate mode,
// receive-ready, transmit-ready, sequence bit and flush pulse.
// Assumes the top has already qualified each event with the endpoint
// number; KIND picks control, bulk or interrupt behaviour.
module ep_hs_slot
    import ep_hs_pkg::*;
#(
    parameter int KIND = EK_BULK
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bus_rst,
    input  logic attr_we,
    input  logic cfg_d,
    input  logic stall_d,
    input  logic mode_we,
    input  logic dir_in_d,
    input  logic rate_d,
    input  logic tx_set,
    input  logic rx_clr,
    input  logic seq_clr,
    input  logic flush_req,
    input  logic rx_good,
    input  logic setup_good,
    input  logic ack_hit,
    output logic cfg_q,
    output logic stall_q,
    output logic rx_rdy_q,
    output logic tx_rdy_q,
    output logic seq_q,
    output logic flush_q,
    output logic is_in,
    output logic is_out
);
    localparam logic IS_CTRL = (KIND == EK_CTRL);
    localparam logic IS_BULK = (KIND == EK_BULK);
    localparam logic IS_INTR = (KIND == EK_INTR);

    logic dir_q;
    logic rate_q;
    logic rate_act;
    logic arm_ok;
    logic flush_hit;
    logic flip;

    assign is_in     = IS_CTRL | IS_INTR | (IS_BULK & dir_q);
    assign is_out    = IS_CTRL | (IS_BULK & ~dir_q);
    assign rate_act  = IS_INTR & rate_q;
    assign arm_ok    = tx_set & is_in;
    assign flush_hit = flush_req & is_in;
    assign flip      = rx_good | (ack_hit & ~rate_act) | (arm_ok & rate_act);

    // Configured bit: control endpoint follows bus reset, others follow writes.
    always_ff @(posedge clk) begin
        if (!rst_n)                  cfg_q <= 1'b0;
        else if (bus_rst)            cfg_q <= IS_CTRL;
        else if (attr_we && !IS_CTRL) cfg_q <= cfg_d;
    end

    // Stall bit: loaded by write, dropped by bus reset or a new setup.
    always_ff @(posedge clk) begin
        if (!rst_n)          stall_q <= 1'b0;
        else if (bus_rst)    stall_q <= 1'b0;
        else if (setup_good) stall_q <= 1'b0;
        else if (attr_we)    stall_q <= stall_d;
    end

    // Direction and rate-feedback mode bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dir_q  <= 1'b0;
            rate_q <= 1'b0;
        end else if (mode_we) begin
            dir_q  <= dir_in_d;
            rate_q <= rate_d;
        end
    end

    // Receive-ready: set by a good packet, cleared by a release write.
    always_ff @(posedge clk) begin
        if (!rst_n)                      rx_rdy_q <= 1'b0;
        else if (bus_rst)                rx_rdy_q <= 1'b0;
        else if (rx_good || setup_good)  rx_rdy_q <= 1'b1;
        else if (rx_clr)                 rx_rdy_q <= 1'b0;
    end

    // Transmit-ready: set by an arm write, cleared by ACK or flush.
    always_ff @(posedge clk) begin
        if (!rst_n)                     tx_rdy_q <= 1'b0;
        else if (bus_rst)               tx_rdy_q <= 1'b0;
        else if (arm_ok)                tx_rdy_q <= 1'b1;
        else if (ack_hit || flush_hit)  tx_rdy_q <= 1'b0;
    end

    // Sequence bit: forced, preset by setup, or flipped by traffic.
    always_ff @(posedge clk) begin
        if (!rst_n)          seq_q <= 1'b0;
        else if (bus_rst)    seq_q <= 1'b0;
        else if (seq_clr)    seq_q <= 1'b0;
        else if (setup_good) seq_q <= 1'b1;
        else if (flip)       seq_q <= ~seq_q;
    end

    // Flush pulse towards the FIFO array.
    always_ff @(posedge clk) begin
        if (!rst_n) flush_q <= 1'b0;
        else        flush_q <= flush_hit;
    end

    a_r3_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rx_clr && !rx_good && !setup_good && !bus_rst |=> !rx_rdy_q);
    a_r4_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit && !arm_ok && !bus_rst |=> !tx_rdy_q);
    a_r7_seq_forced: assert property (@(posedge clk) disable iff (!rst_n)
        seq_clr && !bus_rst |=> !seq_q);
    a_r5_bus_reset: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst |=> (cfg_q == IS_CTRL) && !tx_rdy_q && !rx_rdy_q && !stall_q && !seq_q);
    a_r8_rate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rate_act && ack_hit && !rx_good && !arm_ok && !seq_clr && !setup_good && !bus_rst
        |=> $stable(seq_q));
endmodule

// File: rtl/ep_hs_resp.sv
// Token responder: decides none/accept/NAK/STALL and the data PID parity
// for each token, registered one cycle after tok_valid.
// Assumes per-endpoint state vectors are current in the token cycle.
module ep_hs_resp
    import ep_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tok_valid,
    input  logic [EP_W-1:0] tok_ep,
    input  tok_kind_e       tok_kind,
    input  logic [NUM_EP-1:0] cfg_i,
    input  logic [NUM_EP-1:0] stall_i,
    input  logic [NUM_EP-1:0] rx_rdy_i,
    input  logic [NUM_EP-1:0] tx_rdy_i,
    input  logic [NUM_EP-1:0] seq_i,
    input  logic [NUM_EP-1:0] is_in_i,
    input  logic [NUM_EP-1:0] is_out_i,
    input  logic            setup_rdy_i,
    output logic            hs_valid_q,
    output hs_code_e        hs_code_q,
    output logic            hs_pid_q,
    output logic [EP_W-1:0] hs_ep_q,
    output tok_kind_e       hs_kind_q
);
    hs_code_e code_d;
    logic     ep0_hit;
    logic     locked;

    assign ep0_hit = (tok_ep == '0);
    assign locked  = rx_rdy_i[tok_ep] | (ep0_hit & setup_rdy_i);

    // Handshake decision for the token present this cycle.
    always_comb begin
        code_d = HS_NONE;
        case (tok_kind)
            TK_SETUP: if (ep0_hit && cfg_i[0]) code_d = HS_GO;
            TK_OUT: if (cfg_i[tok_ep] && is_out_i[tok_ep]) begin
                if (stall_i[tok_ep])  code_d = HS_STALL;
                else if (locked)      code_d = HS_NAK;
                else                  code_d = HS_GO;
            end
            TK_IN: if (cfg_i[tok_ep] && is_in_i[tok_ep]) begin
                if (stall_i[tok_ep])       code_d = HS_STALL;
                else if (tx_rdy_i[tok_ep]) code_d = HS_GO;
                else                       code_d = HS_NAK;
            end
            default: code_d = HS_NONE;
        endcase
    end

    // Register the answer so it is presented one cycle after the token.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hs_valid_q <= 1'b0;
            hs_code_q  <= HS_NONE;
            hs_pid_q   <= 1'b0;
            hs_ep_q    <= '0;
            hs_kind_q  <= TK_OUT;
        end else begin
            hs_valid_q <= tok_valid;
            hs_code_q  <= tok_valid ? code_d : HS_NONE;
            if (tok_valid) begin
                hs_pid_q  <= seq_i[tok_ep];
                hs_ep_q   <= tok_ep;
                hs_kind_q <= tok_kind;
            end
        end
    end

    a_r5_unconfigured_silent: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && !cfg_i[tok_ep] |=> hs_code_q == HS_NONE);
    a_r6_stall_wins: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && (tok_kind == TK_OUT || tok_kind == TK_IN) && stall_i[tok_ep]
        |=> hs_code_q == HS_NONE || hs_code_q == HS_STALL);
    a_r2_locked_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_OUT && rx_rdy_i[tok_ep] |=> hs_code_q != HS_GO);
    a_r4_unarmed_no_accept: assert property (@(posedge clk) disable iff (!rst_n)
        tok_valid && tok_kind == TK_IN && !tx_rdy_i[tok_ep] |=> hs_code_q != HS_GO);
endmodule

// File: rtl/ep_hs_stage.sv
// Endpoint 0 control-transfer tracker: setup-ready flag and the
// setup/data/status stage. Assumes accepted tokens are reported by the
// responder one cycle after arrival.
module ep_hs_stage
    import ep_hs_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_rst,
    input  logic            setup_good,
    input  logic            setup_in,
    input  logic            setup_len_nz,
    input  logic            setupack_we,
    input  logic            hs_valid,
    input  hs_code_e        hs_code,
    input  logic [EP_W-1:0] hs_ep,
    input  tok_kind_e       hs_kind,
    input  logic            ack0,
    input  logic            rx_good0,
    output ep0_stage_e      stage_q,
    output logic            setup_rdy_q,
    output logic            clr_rx0
);
    logic ctl_in_q;
    logic ctl_wdata_q;
    logic turn_tok;
    logic status_done;

    assign clr_rx0     = setupack_we & ctl_wdata_q;
    assign turn_tok    = hs_valid && hs_code == HS_GO && hs_ep == '0 &&
                         hs_kind != TK_SETUP && ((hs_kind == TK_IN) != ctl_in_q);
    assign status_done = ctl_in_q ? rx_good0 : ack0;

    // Stage, direction and setup-ready bookkeeping for control transfers.
    always_ff @(posedge clk) begin
        if (!rst_n || bus_rst) begin
            stage_q     <= ST_SETUP;
            setup_rdy_q <= 1'b0;
            ctl_in_q    <= 1'b0;
            ctl_wdata_q <= 1'b0;
        end else if (setup_good) begin
            setup_rdy_q <= 1'b1;
            ctl_in_q    <= setup_in;
            ctl_wdata_q <= ~setup_in & setup_len_nz;
            stage_q     <= setup_len_nz ? ST_DATA : ST_STATUS;
        end else begin
            if (setupack_we) setup_rdy_q <= 1'b0;
            case (stage_q)
                ST_DATA:   if (turn_tok)    stage_q <= ST_STATUS;
                ST_STATUS: if (status_done) stage_q <= ST_SETUP;
                ST_SETUP:  stage_q <= ST_SETUP;
                default:   stage_q <= ST_SETUP;
            endcase
        end
    end

    a_r9_setup_flag: assert property (@(posedge clk) disable iff (!rst_n)
        setup_good && !bus_rst |=> setup_rdy_q && stage_q != ST_SETUP);
    a_r11_status_exit: assert property (@(posedge clk) disable iff (!rst_n)
        stage_q == ST_STATUS && status_done && !setup_good && !bus_rst |=> stage_q == ST_SETUP);
endmodule

// File: rtl/ep_hs_ctrl.sv
// Top of the endpoint handshake and toggle controller. Decodes processor
// writes into per-endpoint strobes, qualifies protocol-engine events by
// endpoint, and instantiates one slot per endpoint, the token responder
// and the endpoint 0 stage tracker. Assumes events arrive as one-cycle pulses.
module ep_hs_ctrl
    import ep_hs_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_reset_i,
    input  logic        tok_valid_i,
    input  logic [1:0]  tok_ep_i,
    input  logic [1:0]  tok_kind_i,
    input  logic        rx_done_i,
    input  logic        rx_err_i,
    input  logic [1:0]  rx_ep_i,
    input  logic        rx_setup_i,
    input  logic        setup_in_dir_i,
    input  logic        setup_len_nz_i,
    input  logic        ack_i,
    input  logic [1:0]  ack_ep_i,
    input  logic        wr_en_i,
    input  logic [2:0]  wr_addr_i,
    input  logic [7:0]  wr_data_i,
    output logic        hs_valid_o,
    output logic [1:0]  hs_code_o,
    output logic        hs_pid_odd_o,
    output logic [3:0]  cfg_o,
    output logic [3:0]  stall_o,
    output logic [3:0]  rx_ready_o,
    output logic [3:0]  tx_ready_o,
    output logic [3:0]  seq_o,
    output logic        setup_ready_o,
    output logic [1:0]  ep0_stage_o,
    output logic [3:0]  flush_o
);
    logic we_arm, we_rel, we_attr, we_mode, we_seq, we_flush, we_sack;
    logic rx_ok, setup_good, rx_good0, clr_rx0, setup_rdy;
    logic [NUM_EP-1:0] cfg, stall, rx_rdy, tx_rdy, seq, flush, is_in, is_out;
    logic [NUM_EP-1:0] rx_good, ack_hit;
    logic              hs_valid, hs_pid;
    hs_code_e          hs_code;
    logic [EP_W-1:0]   hs_ep;
    tok_kind_e         hs_kind;
    ep0_stage_e        stage;

    assign we_arm   = wr_en_i && wr_addr_i == RA_ARM;
    assign we_rel   = wr_en_i && wr_addr_i == RA_RELEASE;
    assign we_attr  = wr_en_i && wr_addr_i == RA_ATTR;
    assign we_mode  = wr_en_i && wr_addr_i == RA_MODE;
    assign we_seq   = wr_en_i && wr_addr_i == RA_SEQCLR;
    assign we_flush = wr_en_i && wr_addr_i == RA_FLUSH;
    assign we_sack  = wr_en_i && wr_addr_i == RA_SETUPACK && wr_data_i[0];

    assign rx_ok      = rx_done_i && !rx_err_i;
    assign setup_good = rx_ok && rx_setup_i && rx_ep_i == '0 && cfg[0];
    assign rx_good0   = rx_good[0];

    for (genvar k = 0; k < NUM_EP; k++) begin : g_ep
        localparam int KND = (k == 0) ? EK_CTRL : ((k == NUM_EP - 1) ? EK_INTR : EK_BULK);
        logic dir_d;
        logic rx_clr;

        if (k == 1)      begin : g_d1 assign dir_d = wr_data_i[0]; end
        else if (k == 2) begin : g_d2 assign dir_d = wr_data_i[1]; end
        else             begin : g_dx assign dir_d = 1'b0;         end

        assign rx_clr     = ((k < NUM_EP - 1) && we_rel && wr_data_i[k]) || ((k == 0) && clr_rx0);
        assign rx_good[k] = rx_ok && !rx_setup_i && rx_ep_i == EP_W'(k) && cfg[k] && is_out[k];
        assign ack_hit[k] = ack_i && ack_ep_i == EP_W'(k);

        ep_hs_slot #(.KIND(KND)) i_slot (
            .clk       (clk),
            .rst_n     (rst_n),
            .bus_rst   (bus_reset_i),
            .attr_we   (we_attr),
            .cfg_d     (wr_data_i[k]),
            .stall_d   (wr_data_i[4 + k]),
            .mode_we   (we_mode),
            .dir_in_d  (dir_d),
            .rate_d    (wr_data_i[2]),
            .tx_set    (we_arm && wr_data_i[k]),
            .rx_clr    (rx_clr),
            .seq_clr   (we_seq && wr_data_i[k]),
            .flush_req ((k != 0) && we_flush && wr_data_i[k]),
            .rx_good   (rx_good[k]),
            .setup_good((k == 0) && setup_good),
            .ack_hit   (ack_hit[k]),
            .cfg_q     (cfg[k]),
            .stall_q   (stall[k]),
            .rx_rdy_q  (rx_rdy[k]),
            .tx_rdy_q  (tx_rdy[k]),
            .seq_q     (seq[k]),
            .flush_q   (flush[k]),
            .is_in     (is_in[k]),
            .is_out    (is_out[k])
        );
    end

    ep_hs_resp i_resp (
        .clk        (clk),
        .rst_n      (rst_n),
        .tok_valid  (tok_valid_i),
        .tok_ep     (tok_ep_i),
        .tok_kind   (tok_kind_e'(tok_kind_i)),
        .cfg_i      (cfg),
        .stall_i    (stall),
        .rx_rdy_i   (rx_rdy),
        .tx_rdy_i   (tx_rdy),
        .seq_i      (seq),
        .is_in_i    (is_in),
        .is_out_i   (is_out),
        .setup_rdy_i(setup_rdy),
        .hs_valid_q (hs_valid),
        .hs_code_q  (hs_code),
        .hs_pid_q   (hs_pid),
        .hs_ep_q    (hs_ep),
        .hs_kind_q  (hs_kind)
    );

    ep_hs_stage i_stage (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_rst     (bus_reset_i),
        .setup_good  (setup_good),
        .setup_in    (setup_in_dir_i),
        .setup_len_nz(setup_len_nz_i),
        .setupack_we (we_sack),
        .hs_valid    (hs_valid),
        .hs_code     (hs_code),
        .hs_ep       (hs_ep),
        .hs_kind     (hs_kind),
        .ack0        (ack_hit[0]),
        .rx_good0    (rx_good0),
        .stage_q     (stage),
        .setup_rdy_q (setup_rdy),
        .clr_rx0     (clr_rx0)
    );

    assign hs_valid_o    = hs_valid;
    assign hs_code_o     = hs_code;
    assign hs_pid_odd_o  = hs_pid;
    assign cfg_o         = cfg;
    assign stall_o       = stall;
    assign rx_ready_o    = rx_rdy;
    assign tx_ready_o    = tx_rdy;
    assign seq_o         = seq;
    assign setup_ready_o = setup_rdy;
    assign ep0_stage_o   = stage;
    assign flush_o       = flush;

    a_r10_flush_only_tx: assert property (@(posedge clk) disable iff (!rst_n)
        we_flush && wr_data_i[1] && !is_in[1] |=> !flush[1]);
    a_r12_error_no_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rx_done_i && rx_err_i && !bus_reset_i && !wr_en_i && !ack_i |=> $stable(rx_rdy) && $stable(seq));
endmodule

// File: tb/test_ep_hs_ctrl.sv
// Scoreboard bench: token tasks push expected handshakes into a queue,
// a monitor pops and compares them whenever hs_valid_o is seen.
module test_ep_hs_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_reset = 0, tok_valid = 0, rx_done = 0, rx_err = 0, rx_setup = 0;
    logic       s_in = 0, s_len = 0, ack = 0, wr_en = 0;
    logic [1:0] tok_ep = 0, tok_kind = 0, rx_ep = 0, ack_ep = 0;
    logic [2:0] wr_addr = 0;
    logic [7:0] wr_data = 0;
    logic       hs_valid, hs_pid, setup_ready;
    logic [1:0] hs_code, stage;
    logic [3:0] cfg, stall, rxr, txr, seq, flush;

    int total = 0;
    int bad = 0;
    logic [2:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    ep_hs_ctrl i_ep_hs_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_reset_i(bus_reset),
        .tok_valid_i(tok_valid), .tok_ep_i(tok_ep), .tok_kind_i(tok_kind),
        .rx_done_i(rx_done), .rx_err_i(rx_err), .rx_ep_i(rx_ep), .rx_setup_i(rx_setup),
        .setup_in_dir_i(s_in), .setup_len_nz_i(s_len), .ack_i(ack), .ack_ep_i(ack_ep),
        .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
        .hs_valid_o(hs_valid), .hs_code_o(hs_code), .hs_pid_odd_o(hs_pid),
        .cfg_o(cfg), .stall_o(stall), .rx_ready_o(rxr), .tx_ready_o(txr), .seq_o(seq),
        .setup_ready_o(setup_ready), .ep0_stage_o(stage), .flush_o(flush)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic reg_wr(input logic [2:0] a, input logic [7:0] d);
        wr_en = 1; wr_addr = a; wr_data = d;
        step();
        wr_en = 0; wr_data = 0;
    endtask

    // Send one token and queue the expected {code, pid}.
    task automatic token(input string req, input logic [1:0] ep, input logic [1:0] kind,
                         input logic [1:0] code, input logic pid);
        exp_q.push_back({code, pid});
        tag_q.push_back(req);
        tok_valid = 1; tok_ep = ep; tok_kind = kind;
        step();
        tok_valid = 0;
    endtask

    task automatic rx_pkt(input logic [1:0] ep, input logic setup, input logic err,
                          input logic din, input logic len);
        rx_done = 1; rx_ep = ep; rx_setup = setup; rx_err = err; s_in = din; s_len = len;
        step();
        rx_done = 0; rx_setup = 0; rx_err = 0;
    endtask

    task automatic host_ack(input logic [1:0] ep);
        ack = 1; ack_ep = ep;
        step();
        ack = 0;
    endtask

    task automatic bus_rst();
        bus_reset = 1;
        step();
        bus_reset = 0;
    endtask

    // Monitor: compare each handshake against the scoreboard queue.
    always @(negedge clk) begin
        if (rst_n && hs_valid) begin
            total++;
            if (exp_q.size() == 0) begin
                bad++;
                $display("FAIL handshake unexpected actual=%0h expected=none", hs_code);
            end else begin
                logic [2:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (hs_code !== e[2:1] || (e[2:1] == 2'd1 && hs_pid !== e[0])) begin
                    bad++;
                    $display("FAIL %s handshake actual=%0h/%0b expected=%0h/%0b",
                             t, hs_code, hs_pid, e[2:1], e[0]);
                end
            end
        end
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) step();
        rst_n = 1;
        step();
        // R1 reset state
        chk("R1 cfg", {4'b0, cfg}, 8'h0);
        chk("R1 rx", {4'b0, rxr}, 8'h0);
        chk("R1 tx", {4'b0, txr}, 8'h0);
        chk("R1 seq", {4'b0, seq}, 8'h0);
        chk("R1 stage", {6'b0, stage}, 8'h0);
        chk("R1 flush", {3'b0, setup_ready, flush}, 8'h0);

        // R5 unconfigured endpoint 0 stays silent, then bus reset configures it
        token("R5 unconfigured", 2'd0, 2'd0, 2'd0, 1'b0);
        bus_rst();
        chk("R5 cfg after bus reset", {4'b0, cfg}, 8'h1);
        token("R4 in unarmed nak", 2'd0, 2'd1, 2'd2, 1'b0);

        // R9 setup: control write with data
        token("R9 setup accept", 2'd0, 2'd2, 2'd1, 1'b0);
        rx_pkt(2'd0, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R9 setup ready", {7'b0, setup_ready}, 8'h1);
        chk("R9 rx0 locked", {4'b0, rxr}, 8'h1);
        chk("R9 seq0 preset", {4'b0, seq}, 8'h1);
        chk("R11 stage data", {6'b0, stage}, 8'h1);
        token("R2 locked nak", 2'd0, 2'd0, 2'd2, 1'b0);
        reg_wr(3'd6, 8'h01);
        chk("R9 setup cleared", {7'b0, setup_ready}, 8'h0);
        chk("R9 rx0 released with write data", {4'b0, rxr}, 8'h0);

        // R12 error packet changes nothing
        token("R2 out accept", 2'd0, 2'd0, 2'd1, 1'b1);
        rx_pkt(2'd0, 1'b0, 1'b1, 1'b0, 1'b0);
        chk("R12 rx unchanged", {4'b0, rxr}, 8'h0);
        chk("R12 seq unchanged", {4'b0, seq}, 8'h1);
        token("R2 out accept retry", 2'd0, 2'd0, 2'd1, 1'b1);
        rx_pkt(2'd0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 rx0 set", {4'b0, rxr}, 8'h1);
        chk("R2 seq0 flipped", {4'b0, seq}, 8'h0);

        // R3 write-one-to-clear
        reg_wr(3'd1, 8'h00);
        chk("R3 zero write keeps", {4'b0, rxr}, 8'h1);
        reg_wr(3'd1, 8'h01);
        chk("R3 one write clears", {4'b0, rxr}, 8'h0);

        // R4 / R11 IN data handshake on endpoint 0 moves to status, ACK ends it
        reg_wr(3'd0, 8'h01);
        chk("R4 tx0 armed", {4'b0, txr}, 8'h1);
        token("R4 in accept", 2'd0, 2'd1, 2'd1, 1'b0);
        step();
        chk("R11 stage status", {6'b0, stage}, 8'h2);
        host_ack(2'd0);
        chk("R4 ack clears tx", {4'b0, txr}, 8'h0);
        chk("R4 ack flips seq", {4'b0, seq}, 8'h1);
        chk("R11 stage back to setup", {6'b0, stage}, 8'h0);

        // Bulk endpoints: ep1 IN, ep2 OUT
        reg_wr(3'd2, 8'h06);
        chk("R5 cfg write", {4'b0, cfg}, 8'h7);
        reg_wr(3'd3, 8'h01);
        token("R4 ep1 unarmed", 2'd1, 2'd1, 2'd2, 1'b0);
        reg_wr(3'd0, 8'h02);
        token("R4 ep1 accept", 2'd1, 2'd1, 2'd1, 1'b0);
        host_ack(2'd1);
        chk("R4 ep1 ack", {txr, seq}, 8'h03);
        token("R2 out on in-only", 2'd1, 2'd0, 2'd0, 1'b0);
        token("R2 ep2 accept", 2'd2, 2'd0, 2'd1, 1'b0);
        rx_pkt(2'd2, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R2 ep2 rx", {rxr, seq}, 8'h47);
        token("R2 ep2 locked", 2'd2, 2'd0, 2'd2, 1'b0);
        reg_wr(3'd4, 8'h04);
        chk("R7 seq2 forced", {4'b0, seq}, 8'h3);

        // R6 stall
        reg_wr(3'd2, 8'h26);
        chk("R6 stall bit", {4'b0, stall}, 8'h2);
        token("R6 stall answer", 2'd1, 2'd1, 2'd3, 1'b0);
        reg_wr(3'd2, 8'h06);
        token("R6 unstalled", 2'd1, 2'd1, 2'd2, 1'b0);

        // R8 interrupt endpoint toggle modes
        reg_wr(3'd2, 8'h0E);
        reg_wr(3'd0, 8'h08);
        chk("R8 normal arm no flip", {txr, seq}, 8'h83);
        token("R8 ep3 accept", 2'd3, 2'd1, 2'd1, 1'b0);
        host_ack(2'd3);
        chk("R8 normal ack flips", {txr, seq}, 8'h0B);
        reg_wr(3'd3, 8'h05);
        reg_wr(3'd0, 8'h08);
        chk("R8 rate arm flips", {txr, seq}, 8'h83);
        token("R8 rate accept", 2'd3, 2'd1, 2'd1, 1'b0);
        host_ack(2'd3);
        chk("R8 rate ack holds", {txr, seq}, 8'h03);

        // R10 flush only transmit endpoints
        reg_wr(3'd0, 8'h0A);
        chk("R10 armed", {4'b0, txr}, 8'hA);
        reg_wr(3'd5, 8'h0E);
        chk("R10 flush pulse", {4'b0, flush}, 8'hA);
        chk("R10 tx cleared", {4'b0, txr}, 8'h0);
        step();
        chk("R10 pulse ends", {4'b0, flush}, 8'h0);

        // R5 bus reset clears the rest
        bus_rst();
        chk("R5 bus reset cfg", {4'b0, cfg}, 8'h1);
        chk("R5 bus reset rx/seq", {rxr, seq}, 8'h00);
        token("R5 ep1 unconfigured", 2'd1, 2'd1, 2'd0, 1'b0);

        // R9 control read: setup clear leaves rx0 set
        token("R9 setup accept read", 2'd0, 2'd2, 2'd1, 1'b0);
        rx_pkt(2'd0, 1'b1, 1'b0, 1'b1, 1'b1);
        reg_wr(3'd6, 8'h01);
        chk("R9 read setup cleared", {7'b0, setup_ready}, 8'h0);
        chk("R9 rx0 kept on read", {4'b0, rxr}, 8'h1);

        step();
        chk("scoreboard drained", 8'(exp_q.size()), 8'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule